// File: doc/BRIEF.md
# CAN FD Protocol Status Word

This block holds the read-only protocol status word of a CAN FD controller. The protocol engine sends it single-cycle event pulses: error detections with a 3-bit error code, completion of a frame without error, reception of an FD-format frame with its bit-rate-switch and error-state flags, and protocol exceptions. It also sends level signals: the activity state, the error-passive and bus-off states, both error counters and the measured secondary sample point position. The block registers all of these into one 32-bit word.

A single read strobe stands in for the CPU bus. A read returns the current word and applies side effects in the next state. The last-error field becomes the "no change" code, and the four frame flags clear. While a frame that uses a bit-rate switch is in its fast data phase, error and completion events update a separate data-phase error field, and the normal last-error field is left alone. When an event and a read fall in the same cycle, the event sets its field, and the read side effects apply only to fields that had no event in that cycle.

Top module: `canfd_prot_status`

## Requirements
- R1: After reset the status word reads 0x00000707: last-error field (bits 2:0) = 7, data-phase error field (bits 10:8) = 7, and every other bit 0.
- R2: An error pulse with code 1..6 (1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC) outside the data phase writes that code into bits 2:0 one cycle later. An error pulse with code 0 or 7 is ignored.
- R3: A read sets bits 2:0 to 7 in the next cycle unless an error or completion event targets bits 2:0 in that same cycle. In that case the event value is stored.
- R4: A completion pulse outside the data phase clears bits 2:0 to 0. If a valid error pulse arrives in the same cycle, the error code is stored instead.
- R5: While the data-phase input is high, error and completion events update bits 10:8 with the same coding (completion gives 0) and leave bits 2:0 untouched.
- R6: A stuff error flagged as a fixed stuff bit of the FD CRC sequence is stored as form error (2), in whichever field it targets.
- R7: A read never changes bits 10:8.
- R8: Bit 14 (protocol exception) is set by the exception pulse. An FD-reception pulse sets bit 13 and loads bit 12 (BRS) and bit 11 (ESI) from its flags. A read clears bits 14:11 except for any bit that is being set or loaded by an event in that same cycle.
- R9: Bit 6 is 1 one cycle after either error counter is at or above 96, and 0 otherwise.
- R10: Bits 22:16 (delay value), bit 7 (bus off), bit 5 (error passive) and bits 4:3 (activity: 0 sync, 1 idle, 2 receive, 3 transmit) show their inputs one cycle later. Bits 31:23 and bit 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | CPU read of the status word this cycle |
| err_vld | input | 1 | Error detected pulse |
| err_code | input | 3 | Error type for err_vld |
| err_fix_stuff | input | 1 | Error was in a fixed stuff bit of an FD CRC field |
| frame_ok | input | 1 | Frame sent or received without error |
| data_phase | input | 1 | A BRS frame is in its data phase |
| fd_rx | input | 1 | FD-format frame received pulse |
| fd_rx_brs | input | 1 | BRS flag of that frame |
| fd_rx_esi | input | 1 | ESI flag of that frame |
| proto_exc | input | 1 | Protocol exception pulse |
| activity | input | 2 | Activity state |
| err_passive | input | 1 | Node is error passive |
| bus_off | input | 1 | Node is bus off |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| ssp_pos | input | 7 | Secondary sample point position |
| status_o | output | 32 | Status word |

## Verification
The bench sweeps every combination of read, error code, fixed-stuff flag, completion and data-phase. This catches a read that wins over a same-cycle event, a design that lets a read touch the data-phase field, and codes 0 or 7 leaking into the fields. Error pulses and completion pulses arrive in the same cycle, so a design that lets completion win reports 0 after a real error. Flag events are crossed with reads. A design that clears a flag after setting it, or holds a stale BRS or ESI, shows a wrong bit 11 or 12. The counter sweep crosses 95 and 96 on each counter, which exposes an off-by-one threshold or a check of only one counter.

// File: rtl/canfd_ps_pkg.sv
package canfd_ps_pkg;

    localparam int SSP_W = 7;

    typedef enum logic [2:0] {
        EC_NONE  = 3'd0,
        EC_STUFF = 3'd1,
        EC_FORM  = 3'd2,
        EC_ACK   = 3'd3,
        EC_BIT1  = 3'd4,
        EC_BIT0  = 3'd5,
        EC_CRC   = 3'd6,
        EC_NOCHG = 3'd7
    } err_code_e;

    typedef struct packed {
        logic [SSP_W-1:0] ssp;
        logic             pexc;
        logic             fd_seen;
        logic             fd_brs;
        logic             fd_esi;
        err_code_e        dp_err;
        logic             boff;
        logic             warn;
        logic             epass;
        logic [1:0]       act;
        err_code_e        last_err;
    } ps_state_t;

    localparam ps_state_t PS_RESET = '{
        ssp:      '0,
        pexc:     1'b0,
        fd_seen:  1'b0,
        fd_brs:   1'b0,
        fd_esi:   1'b0,
        dp_err:   EC_NOCHG,
        boff:     1'b0,
        warn:     1'b0,
        epass:    1'b0,
        act:      2'd0,
        last_err: EC_NOCHG
    };

endpackage

// File: rtl/canfd_ps_errmap.sv
module canfd_ps_errmap
    import canfd_ps_pkg::*;
(
    input  logic      vld_i,
    input  logic [2:0] code_i,
    input  logic      fix_stuff_i,
    output logic      hit_o,
    output err_code_e code_o
);
    always_comb begin
        hit_o  = vld_i && (code_i != 3'd0) && (code_i != 3'd7);
        code_o = err_code_e'(code_i);
        if (code_i == EC_STUFF && fix_stuff_i) begin
            code_o = EC_FORM;
        end
    end
endmodule

// File: rtl/canfd_ps_warn.sv
module canfd_ps_warn #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 96
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    output logic             warn_o
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    always_comb begin
        warn_o = (tec_i >= LIM_V) || (rec_i >= LIM_V);
    end
endmodule

// File: rtl/canfd_prot_status.sv
module canfd_prot_status
    import canfd_ps_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WARN_LIMIT = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             err_vld,
    input  logic [2:0]       err_code,
    input  logic             err_fix_stuff,
    input  logic             frame_ok,
    input  logic             data_phase,
    input  logic             fd_rx,
    input  logic             fd_rx_brs,
    input  logic             fd_rx_esi,
    input  logic             proto_exc,
    input  logic [1:0]       activity,
    input  logic             err_passive,
    input  logic             bus_off,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic [SSP_W-1:0] ssp_pos,
    output logic [31:0]      status_o
);
    localparam int PAD_W = 32 - SSP_W - 16;

    ps_state_t st_d, st_q;
    logic      err_hit;
    err_code_e err_norm;
    logic      warn_now;

    canfd_ps_errmap u_errmap (
        .vld_i      (err_vld),
        .code_i     (err_code),
        .fix_stuff_i(err_fix_stuff),
        .hit_o      (err_hit),
        .code_o     (err_norm)
    );

    canfd_ps_warn #(.CNT_W(CNT_W), .LIMIT(WARN_LIMIT)) u_warn (
        .tec_i (tx_err_cnt),
        .rec_i (rx_err_cnt),
        .warn_o(warn_now)
    );

    always_comb begin
        logic      evt;
        err_code_e evt_code;
        st_d     = st_q;
        evt      = err_hit || frame_ok;
        evt_code = err_hit ? err_norm : EC_NONE;

        // error / completion routing
        if (evt && !data_phase) begin
            st_d.last_err = evt_code;
        end else if (rd_stb) begin
            st_d.last_err = EC_NOCHG;
        end
        if (evt && data_phase) begin
            st_d.dp_err = evt_code;
        end

        // flags cleared on read, events take priority
        if (proto_exc) begin
            st_d.pexc = 1'b1;
        end else if (rd_stb) begin
            st_d.pexc = 1'b0;
        end
        if (fd_rx) begin
            st_d.fd_seen = 1'b1;
            st_d.fd_brs  = fd_rx_brs;
            st_d.fd_esi  = fd_rx_esi;
        end else if (rd_stb) begin
            st_d.fd_seen = 1'b0;
            st_d.fd_brs  = 1'b0;
            st_d.fd_esi  = 1'b0;
        end

        // mirrored levels
        st_d.ssp   = ssp_pos;
        st_d.boff  = bus_off;
        st_d.epass = err_passive;
        st_d.act   = activity;
        st_d.warn  = warn_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o = {{PAD_W{1'b0}}, st_q.ssp, 1'b0,
                    st_q.pexc, st_q.fd_seen, st_q.fd_brs, st_q.fd_esi,
                    st_q.dp_err, st_q.boff, st_q.warn, st_q.epass,
                    st_q.act, st_q.last_err};
    end
endmodule

// File: rtl/canfd_prot_status_chk.sv
module canfd_prot_status_chk #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic             err_vld,
    input logic [2:0]       err_code,
    input logic             err_fix_stuff,
    input logic             frame_ok,
    input logic             data_phase,
    input logic             fd_rx,
    input logic             proto_exc,
    input logic [CNT_W-1:0] tx_err_cnt,
    input logic [CNT_W-1:0] rx_err_cnt,
    input logic [31:0]      status_o
);
    // R3
    a_r3_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !err_vld && !frame_ok |=> status_o[2:0] == 3'd7);

    // R4
    a_r4_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok && !err_vld && !data_phase |=> status_o[2:0] == 3'd0);

    // R6
    a_r6_fixed_stuff_form: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld && err_code == 3'd1 && err_fix_stuff && !data_phase
        |=> status_o[2:0] == 3'd2);

    // R7
    a_r7_dlec_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase |=> $stable(status_o[10:8]));

    // R8
    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !fd_rx && !proto_exc |=> status_o[14:11] == 4'd0);

    // R9
    a_r9_warn_level: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt >= CNT_W'(LIMIT)) || (rx_err_cnt >= CNT_W'(LIMIT))
        |=> status_o[6]);
endmodule

bind canfd_prot_status canfd_prot_status_chk #(
    .CNT_W(CNT_W),
    .LIMIT(WARN_LIMIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_stb       (rd_stb),
    .err_vld      (err_vld),
    .err_code     (err_code),
    .err_fix_stuff(err_fix_stuff),
    .frame_ok     (frame_ok),
    .data_phase   (data_phase),
    .fd_rx        (fd_rx),
    .proto_exc    (proto_exc),
    .tx_err_cnt   (tx_err_cnt),
    .rx_err_cnt   (rx_err_cnt),
    .status_o     (status_o)
);

// File: tb/canfd_prot_status_bench.sv
module canfd_prot_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 0, err_vld = 0, err_fix_stuff = 0, frame_ok = 0;
    logic        data_phase = 0, fd_rx = 0, fd_rx_brs = 0, fd_rx_esi = 0, proto_exc = 0;
    logic [2:0]  err_code = 0;
    logic [1:0]  activity = 0;
    logic        err_passive = 0, bus_off = 0;
    logic [7:0]  tx_err_cnt = 0, rx_err_cnt = 0;
    logic [6:0]  ssp_pos = 0;
    logic [31:0] status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [2:0] e_lec = 3'd7, e_dlec = 3'd7;
    logic [3:0] e_flags = 4'd0;

    always #4 clk = ~clk;

    canfd_prot_status u_canfd_prot_status (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .err_vld(err_vld),
        .err_code(err_code), .err_fix_stuff(err_fix_stuff), .frame_ok(frame_ok),
        .data_phase(data_phase), .fd_rx(fd_rx), .fd_rx_brs(fd_rx_brs),
        .fd_rx_esi(fd_rx_esi), .proto_exc(proto_exc), .activity(activity),
        .err_passive(err_passive), .bus_off(bus_off), .tx_err_cnt(tx_err_cnt),
        .rx_err_cnt(rx_err_cnt), .ssp_pos(ssp_pos), .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one cycle of event stimulus, expected state updated from the requirements
    task automatic step(input bit rd, input bit ev, input logic [2:0] code, input bit fix,
                        input bit ok, input bit dph, input bit fdr, input bit brs,
                        input bit esi, input bit pxe);
        bit         hit;
        logic [2:0] mcode;
        @(negedge clk);
        rd_stb = rd; err_vld = ev; err_code = code; err_fix_stuff = fix;
        frame_ok = ok; data_phase = dph; fd_rx = fdr; fd_rx_brs = brs;
        fd_rx_esi = esi; proto_exc = pxe;
        hit   = ev && code != 3'd0 && code != 3'd7;
        mcode = (code == 3'd1 && fix) ? 3'd2 : code;
        if ((hit || ok) && !dph) e_lec = hit ? mcode : 3'd0;   // R2 R4 R6
        else if (rd)             e_lec = 3'd7;                 // R3
        if ((hit || ok) && dph)  e_dlec = hit ? mcode : 3'd0;  // R5 R7
        if (pxe) e_flags[3] = 1'b1; else if (rd) e_flags[3] = 1'b0;  // R8
        if (fdr) e_flags[2:0] = {1'b1, brs, esi};
        else if (rd) e_flags[2:0] = 3'b000;
        @(negedge clk);
        rd_stb = 0; err_vld = 0; frame_ok = 0; fd_rx = 0; proto_exc = 0;
        check("R2/R3/R4/R6 last error", {29'd0, status_o[2:0]}, {29'd0, e_lec});
        check("R5/R7 data-phase error", {29'd0, status_o[10:8]}, {29'd0, e_dlec});
        check("R8 flags", {28'd0, status_o[14:11]}, {28'd0, e_flags});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #13;
        check("R1 reset value", status_o, 32'h0000_0707);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", status_o, 32'h0000_0707);

        // R2..R7: full cross of read, code, fixed stuff, completion, phase
        for (int pre = 0; pre < 2; pre++)
        for (int rd = 0; rd < 2; rd++)
        for (int dph = 0; dph < 2; dph++)
        for (int fx = 0; fx < 2; fx++)
        for (int ok = 0; ok < 2; ok++)
        for (int c = 0; c < 8; c++) begin
            // seed a non-zero last error so clears and holds are visible
            if (pre == 1) step(0, 1, 3'd3, 0, 0, 0, 0, 0, 0, 0);
            step(rd[0], 1'b1, 3'(c), fx[0], ok[0], dph[0], 0, 0, 0, 0);
        end
        // completion alone in data phase, then a read that must not touch R7 field
        step(0, 0, 3'd0, 0, 1, 1, 0, 0, 0, 0);
        step(1, 0, 3'd0, 0, 0, 0, 0, 0, 0, 0);

        // R8: flag events crossed with reads
        for (int rd = 0; rd < 2; rd++)
        for (int f = 0; f < 16; f++) begin
            step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
            step(rd[0], 0, 0, 0, 0, 0, f[0], f[1], f[2], f[3]);
        end

        // R9: warning threshold on each counter
        for (int w = 0; w < 2; w++)
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            tx_err_cnt = w ? 8'd0 : 8'(v);
            rx_err_cnt = w ? 8'(v) : 8'd0;
            @(negedge clk);
            check("R9 warning", {31'd0, status_o[6]}, {31'd0, (v >= 96)});
        end
        tx_err_cnt = 0; rx_err_cnt = 0;

        // R10: mirrored levels and zero padding
        for (int t = 0; t < 128; t++) begin
            @(negedge clk);
            ssp_pos = 7'(t); activity = 2'(t); err_passive = t[2]; bus_off = t[3];
            @(negedge clk);
            check("R10 mirrors",
                  {status_o[31:15], status_o[7], status_o[5:3]},
                  {9'd0, 7'(t), 1'b0, t[3], t[2], 2'(t)});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule